// File: doc/BRIEF.md
# Mode-Triggered DRAM Command Issue Unit

This unit sits inside a DRAM controller and turns ordinary host write accesses into special memory commands. Software first writes a small mode register that names the command it wants: normal operation, NOP, precharge of all banks, load of the base mode register, auto-refresh, or load of an extended mode register. Writing the mode register by itself sends nothing to the memory. The command goes out only when the host next writes anywhere in the memory window. That write acts as the trigger.

For the mode-register loads, the write address carries the command's operands. The bank-address bits sit at a parameterised position in the host address and select which extended register is loaded. A payload field taken from lower address bits supplies the register value. The mode register stays set until software changes it, so one setting can be used for several commands in a row. The register can be read back, which lets software make sure its mode write has landed before it issues the triggering access. In normal mode the unit forwards memory writes as plain data writes.

Top module: `cmdiss_top`

## Requirements
- R1: After reset the mode readback is 0 (normal), and neither `cmd_valid` nor `data_wr_valid` is asserted.
- R2: A mode write with a value from 0 to 5 is stored and appears on `mode_rd` from the cycle after the write. The codes are: 0 normal, 1 NOP, 2 precharge-all, 3 load mode register, 4 auto-refresh, 5 load extended mode register.
- R3: A mode write with value 6 or 7 is ignored, and `mode_rd` keeps its previous value.
- R4: A mode write on its own never asserts `cmd_valid`.
- R5: In mode 0, a memory write asserts `data_wr_valid` for one cycle, on the cycle after the write, with `data_wr_addr` equal to the write address. `cmd_valid` stays low.
- R6: In modes 1 to 5, each memory write asserts `cmd_valid` for exactly one cycle, on the cycle after the write, with `cmd_op` equal to the mode code. `data_wr_valid` stays low.
- R7: For NOP, precharge-all and auto-refresh, `cmd_ba` and `cmd_payload` are zero whatever the write address.
- R8: For a base mode-register load, `cmd_ba` is forced to zero and `cmd_payload` equals address bits [PAY_LSB+PAY_W-1:PAY_LSB] (bits [15:2] by default).
- R9: For an extended mode-register load, `cmd_ba` equals address bits [BA_LSB+BA_W-1:BA_LSB] (bits [23:21] by default), so a BA[1:0] of 01, 10 or 11 selects extended register 1, 2 or 3. `cmd_payload` is taken as in R8.
- R10: The mode holds across triggering writes: back-to-back memory writes each emit their own command, and `mode_rd` is unchanged afterwards.
- R11: When a mode write and a memory write arrive in the same cycle, the memory write uses the mode that was in force before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_en | input | 1 | Mode register write strobe |
| mode_wr_val | input | 3 | Mode value to write |
| mode_rd | output | 3 | Mode register readback |
| mem_wr_valid | input | 1 | Host write into the memory window |
| mem_wr_addr | input | ADDR_W | Address of the host memory write |
| cmd_valid | output | 1 | One-cycle special command strobe |
| cmd_op | output | 3 | Command code (the mode in force) |
| cmd_ba | output | BA_W | Bank address of the command |
| cmd_payload | output | PAY_W | Mode-register value carried by the command |
| data_wr_valid | output | 1 | Ordinary data write forwarded in normal mode |
| data_wr_addr | output | ADDR_W | Address of the forwarded data write |

## Verification
The bench sets high bank and payload bits on every triggering address. A unit that leaked the address into NOP, precharge or refresh commands would then show a nonzero bank, and a load of the base mode register that did not force bank zero would hit a wrong register. Each extended register (01, 10, 11) is triggered separately, so a shifted or truncated bank field shows up as a wrong selection. Illegal mode codes and same-cycle mode and memory writes are also covered. A unit that stored illegal codes, or that decoded the trigger with the new mode, would produce a different `cmd_op` or readback. Back-to-back triggers catch a unit that clears the mode or swallows the second command.

// File: rtl/cmdiss_pkg.sv
package cmdiss_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL  = 3'd0,
    MODE_NOP     = 3'd1,
    MODE_PREALL  = 3'd2,
    MODE_LMR     = 3'd3,
    MODE_REFRESH = 3'd4,
    MODE_ELMR    = 3'd5
  } mode_e;

  function automatic logic mode_is_legal(input logic [MODE_W-1:0] v);
    return v <= 3'd5;
  endfunction

  function automatic logic mode_has_operand(input mode_e m);
    return (m == MODE_LMR) || (m == MODE_ELMR);
  endfunction

endpackage

// File: rtl/cmdiss_mode_reg.sv
module cmdiss_mode_reg
  import cmdiss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_val,
  output mode_e             mode_q,
  output logic              wr_accept
);

  assign wr_accept = wr_en && mode_is_legal(wr_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
    end else if (wr_accept) begin
      mode_q <= mode_e'(wr_val);
    end
  end

endmodule

// File: rtl/cmdiss_decode.sv
module cmdiss_decode
  import cmdiss_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int BA_LSB  = 21,
  parameter int BA_W    = 3,
  parameter int PAY_LSB = 2,
  parameter int PAY_W   = 14
) (
  input  mode_e             mode,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              fire_cmd,
  output logic              fire_data,
  output logic [BA_W-1:0]   ba_sel,
  output logic [PAY_W-1:0]  pay_sel
);

  function automatic logic [BA_W-1:0] bank_field(input logic [ADDR_W-1:0] a);
    return a[BA_LSB +: BA_W];
  endfunction

  function automatic logic [PAY_W-1:0] payload_field(input logic [ADDR_W-1:0] a);
    return a[PAY_LSB +: PAY_W];
  endfunction

  assign fire_cmd  = wr_valid && (mode != MODE_NORMAL);
  assign fire_data = wr_valid && (mode == MODE_NORMAL);

  always_comb begin
    ba_sel  = '0;
    pay_sel = '0;
    if (mode_has_operand(mode)) begin
      pay_sel = payload_field(wr_addr);
    end
    if (mode == MODE_ELMR) begin
      ba_sel = bank_field(wr_addr);
    end
  end

endmodule

// File: rtl/cmdiss_out_stage.sv
module cmdiss_out_stage
  import cmdiss_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BA_W   = 3,
  parameter int PAY_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_cmd,
  input  logic              fire_data,
  input  mode_e             mode,
  input  logic [BA_W-1:0]   ba_sel,
  input  logic [PAY_W-1:0]  pay_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              cmd_valid,
  output logic [MODE_W-1:0] cmd_op,
  output logic [BA_W-1:0]   cmd_ba,
  output logic [PAY_W-1:0]  cmd_payload,
  output logic              data_wr_valid,
  output logic [ADDR_W-1:0] data_wr_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid     <= 1'b0;
      cmd_op        <= '0;
      cmd_ba        <= '0;
      cmd_payload   <= '0;
      data_wr_valid <= 1'b0;
      data_wr_addr  <= '0;
    end else begin
      cmd_valid     <= fire_cmd;
      data_wr_valid <= fire_data;
      if (fire_cmd) begin
        cmd_op      <= mode;
        cmd_ba      <= ba_sel;
        cmd_payload <= pay_sel;
      end
      if (fire_data) begin
        data_wr_addr <= wr_addr;
      end
    end
  end

endmodule

// File: rtl/cmdiss_top.sv
module cmdiss_top
  import cmdiss_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int BA_LSB  = 21,
  parameter int BA_W    = 3,
  parameter int PAY_LSB = 2,
  parameter int PAY_W   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_en,
  input  logic [2:0]        mode_wr_val,
  output logic [2:0]        mode_rd,
  input  logic              mem_wr_valid,
  input  logic [ADDR_W-1:0] mem_wr_addr,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [BA_W-1:0]   cmd_ba,
  output logic [PAY_W-1:0]  cmd_payload,
  output logic              data_wr_valid,
  output logic [ADDR_W-1:0] data_wr_addr
);

  localparam int BA_TOP  = BA_LSB + BA_W;
  localparam int PAY_TOP = PAY_LSB + PAY_W;

  initial begin
    if (BA_TOP > ADDR_W)   $error("bank field exceeds address width");
    if (PAY_TOP > BA_LSB)  $error("payload field overlaps bank field");
  end

  mode_e             mode_q;
  logic              mode_accept;
  logic              fire_cmd;
  logic              fire_data;
  logic [BA_W-1:0]   ba_sel;
  logic [PAY_W-1:0]  pay_sel;

  cmdiss_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (mode_wr_en),
    .wr_val    (mode_wr_val),
    .mode_q    (mode_q),
    .wr_accept (mode_accept)
  );

  assign mode_rd = mode_q;

  cmdiss_decode #(
    .ADDR_W (ADDR_W), .BA_LSB (BA_LSB), .BA_W (BA_W),
    .PAY_LSB(PAY_LSB), .PAY_W (PAY_W)
  ) u_dec (
    .mode      (mode_q),
    .wr_valid  (mem_wr_valid),
    .wr_addr   (mem_wr_addr),
    .fire_cmd  (fire_cmd),
    .fire_data (fire_data),
    .ba_sel    (ba_sel),
    .pay_sel   (pay_sel)
  );

  cmdiss_out_stage #(
    .ADDR_W (ADDR_W), .BA_W (BA_W), .PAY_W (PAY_W)
  ) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire_cmd      (fire_cmd),
    .fire_data     (fire_data),
    .mode          (mode_q),
    .ba_sel        (ba_sel),
    .pay_sel       (pay_sel),
    .wr_addr       (mem_wr_addr),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_ba        (cmd_ba),
    .cmd_payload   (cmd_payload),
    .data_wr_valid (data_wr_valid),
    .data_wr_addr  (data_wr_addr)
  );

endmodule

// File: rtl/cmdiss_checker.sv
module cmdiss_checker #(
  parameter int ADDR_W = 24,
  parameter int BA_W   = 3,
  parameter int PAY_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wr_en,
  input logic [2:0]        mode_wr_val,
  input logic [2:0]        mode_rd,
  input logic              mem_wr_valid,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [BA_W-1:0]   cmd_ba,
  input logic [PAY_W-1:0]  cmd_payload,
  input logic              data_wr_valid,
  input logic              fire_cmd,
  input logic              fire_data
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !cmd_valid && !data_wr_valid && mode_rd == 3'd0);

  a_r3_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_en && mode_wr_val > 3'd5 |=> $stable(mode_rd));

  a_r4_mode_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_valid |=> !cmd_valid && !data_wr_valid);

  a_r5_normal_is_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mode_rd == 3'd0 |=> data_wr_valid && !cmd_valid);

  a_r6_cmd_uses_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mode_rd != 3'd0 |=> cmd_valid && !data_wr_valid && cmd_op == $past(mode_rd));

  a_r7_plain_no_operand: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2 || cmd_op == 3'd4) |-> cmd_ba == '0 && cmd_payload == '0);

  a_r8_base_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd3 |-> cmd_ba == '0);

  a_r6_exclusive_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fire_cmd, fire_data}) <= 1);

endmodule

bind cmdiss_top cmdiss_checker #(
  .ADDR_W (ADDR_W), .BA_W (BA_W), .PAY_W (PAY_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_wr_en    (mode_wr_en),
  .mode_wr_val   (mode_wr_val),
  .mode_rd       (mode_rd),
  .mem_wr_valid  (mem_wr_valid),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .cmd_ba        (cmd_ba),
  .cmd_payload   (cmd_payload),
  .data_wr_valid (data_wr_valid),
  .fire_cmd      (fire_cmd),
  .fire_data     (fire_data)
);

// File: tb/cmdiss_top_bench.sv
module cmdiss_top_bench;

  localparam int ADDR_W = 24;
  localparam int BA_W   = 3;
  localparam int PAY_W  = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_wr_en = 1'b0;
  logic [2:0]        mode_wr_val = '0;
  logic [2:0]        mode_rd;
  logic              mem_wr_valid = 1'b0;
  logic [ADDR_W-1:0] mem_wr_addr = '0;
  logic              cmd_valid;
  logic [2:0]        cmd_op;
  logic [BA_W-1:0]   cmd_ba;
  logic [PAY_W-1:0]  cmd_payload;
  logic              data_wr_valid;
  logic [ADDR_W-1:0] data_wr_addr;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  cmdiss_top u_cmdiss_top (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(input int ba, input int pay, input int low);
    return ADDR_W'((ba << 21) + (pay << 2) + (low & 3));
  endfunction

  task automatic set_mode(input logic [2:0] v);
    @(negedge clk);
    mode_wr_en = 1'b1; mode_wr_val = v;
    @(negedge clk);
    mode_wr_en = 1'b0;
  endtask

  task automatic mem_write(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    mem_wr_valid = 1'b1; mem_wr_addr = a;
    @(negedge clk);
    mem_wr_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mode", 32'(mode_rd), 0);
    chk("R1 cmd_valid", 32'(cmd_valid), 0);
    chk("R1 data_wr_valid", 32'(data_wr_valid), 0);
  endtask

  task automatic t_mode_rw;
    for (int v = 0; v < 6; v++) begin
      set_mode(3'(v));
      chk("R2 readback", 32'(mode_rd), v);
      chk("R4 no cmd on mode write", 32'(cmd_valid), 0);
    end
  endtask

  task automatic t_illegal;
    set_mode(3'd2);
    set_mode(3'd6);
    chk("R3 code 6 ignored", 32'(mode_rd), 2);
    set_mode(3'd7);
    chk("R3 code 7 ignored", 32'(mode_rd), 2);
    @(negedge clk);
    chk("R4 still no cmd", 32'(cmd_valid), 0);
  endtask

  task automatic t_normal;
    logic [ADDR_W-1:0] a;
    a = mk_addr(5, 16'h1234, 1);
    set_mode(3'd0);
    mem_write(a);
    chk("R5 data_wr_valid", 32'(data_wr_valid), 1);
    chk("R5 data_wr_addr", 32'(data_wr_addr), 32'(a));
    chk("R5 no cmd", 32'(cmd_valid), 0);
    @(negedge clk);
    chk("R5 single pulse", 32'(data_wr_valid), 0);
  endtask

  task automatic t_plain(input logic [2:0] m);
    set_mode(m);
    mem_write(mk_addr(7, 14'h3fff, 3));
    chk("R6 cmd_valid", 32'(cmd_valid), 1);
    chk("R6 cmd_op", 32'(cmd_op), 32'(m));
    chk("R6 no data write", 32'(data_wr_valid), 0);
    chk("R7 ba zero", 32'(cmd_ba), 0);
    chk("R7 payload zero", 32'(cmd_payload), 0);
    @(negedge clk);
    chk("R6 one pulse", 32'(cmd_valid), 0);
  endtask

  task automatic t_lmr;
    set_mode(3'd3);
    mem_write(mk_addr(6, 14'h0a5c, 2));
    chk("R8 cmd_op", 32'(cmd_op), 3);
    chk("R8 ba forced zero", 32'(cmd_ba), 0);
    chk("R8 payload", 32'(cmd_payload), 32'h0a5c);
  endtask

  task automatic t_elmr;
    set_mode(3'd5);
    for (int e = 1; e <= 3; e++) begin
      int pay;
      pay = 14'h0100 * e + 7;
      mem_write(mk_addr(e, pay, 0));
      chk("R9 cmd_valid", 32'(cmd_valid), 1);
      chk("R9 ba select", 32'(cmd_ba), e);
      chk("R9 payload", 32'(cmd_payload), pay & 14'h3fff);
    end
  endtask

  task automatic t_hold;
    set_mode(3'd4);
    @(negedge clk);
    mem_wr_valid = 1'b1; mem_wr_addr = mk_addr(1, 1, 0);
    @(negedge clk);
    chk("R10 first cmd", 32'(cmd_valid), 1);
    @(negedge clk);
    mem_wr_valid = 1'b0;
    chk("R10 second cmd", 32'(cmd_valid), 1);
    chk("R10 op", 32'(cmd_op), 4);
    @(negedge clk);
    chk("R10 ends", 32'(cmd_valid), 0);
    chk("R10 mode kept", 32'(mode_rd), 4);
  endtask

  task automatic t_same_cycle;
    set_mode(3'd1);
    @(negedge clk);
    mode_wr_en = 1'b1; mode_wr_val = 3'd0;
    mem_wr_valid = 1'b1; mem_wr_addr = mk_addr(2, 5, 0);
    @(negedge clk);
    mode_wr_en = 1'b0; mem_wr_valid = 1'b0;
    chk("R11 old mode fires", 32'(cmd_valid), 1);
    chk("R11 op is old", 32'(cmd_op), 1);
    chk("R11 no data write", 32'(data_wr_valid), 0);
    chk("R11 new mode stored", 32'(mode_rd), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_rw();
    t_illegal();
    t_normal();
    t_plain(3'd1);
    t_plain(3'd2);
    t_plain(3'd4);
    t_lmr();
    t_elmr();
    t_hold();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_vec++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule